// File: doc/BRIEF.md
# Level-Aware Interrupt Priority Controller

This block gathers one-cycle request pulses from a watchdog and from a set of peripheral sources. It latches each pulse as a pending flag and picks one winner to present to a CPU core. The core sees a registered request line and a registered vector address, which is the table base plus twice the winning source number. The core answers with a one-cycle acknowledge. That acknowledge retires the winner's pending flag and frees the controller to arbitrate again.

Source 0 is the watchdog. It is never masked and it beats every other source. Sources 1 to NUM_MSK are maskable. Each has an enable bit and a 2-bit level, and both are reached through a small byte-wide register port. A control register holds the global enable and the arbitration mode. In fixed mode the smallest source number wins. In level mode the highest level wins, and a tie goes to the smallest number. Level mode also records the level of the source being served. Sources that are not above that level stay pending until software signals end-of-service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_req is 0, irq_vec equals VEC_BASE, and every register reads 0.
- R2: A pulse on src_pulse[i] sets the pending flag of source i+1. Pending byte k (address 8+k) bit b shows the flag of source 8k+b+1.
- R3: A maskable source raises irq_req only while control bit 0 (global enable) is 1 and its enable bit is 1. Enable byte k (address 1+k) bit b belongs to source 8k+b+1.
- R4: A wdt_pulse makes source 0 pending. Source 0 is presented regardless of enables, mode or levels, and it wins over every maskable source.
- R5: With control bit 1 at 0 (fixed mode), the eligible source with the smallest number wins.
- R6: With control bit 1 at 1 (level mode), the highest level wins and ties go to the smallest number. Level byte k (address 16+k) bits [2j+1:2j] hold the level of source 4k+j+1, and 3 is the highest level.
- R7: A source that loses arbitration stays pending and is presented later.
- R8: irq_vec equals VEC_BASE + 2 x (winning source number).
- R9: irq_req and irq_vec stay unchanged from the cycle irq_req rises until cpu_ack is seen. The cycle after cpu_ack, irq_req is 0 and the served source's pending flag is clear.
- R10: Writing 1 to a pending bit clears it and writing 0 leaves it alone. A request pulse in the same cycle as any clear leaves the flag set.
- R11: In level mode, acknowledging a maskable source records its level as the service level. Maskable sources whose level is not above that level stay pending until control bit 3 is written as 1 (end-of-service).
- R12: Reading address 0 returns bit 0 global enable, bit 1 mode, bit 2 service active, bits 5:4 service level and bit 7 watchdog pending. The other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdt_pulse | input | 1 | Non-maskable watchdog request pulse |
| src_pulse | input | NUM_MSK | Maskable request pulses; bit i belongs to source i+1 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for addr (combinational) |
| cpu_ack | input | 1 | CPU acknowledge of the presented request |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | VEC_W | Vector-table entry address of the presented source |

## Verification
A flipped pending, enable or level bit shows up at the ports within two cycles. The register read-back exposes the stored value at once. The next arbitration also presents a wrong vector, or raises or withholds irq_req where it should not. A stuck service level shows as sources held back or let through after end-of-service. The next lower-level pulse makes that visible at irq_req. The bench follows a reference model every cycle, so a drift in any of this state shows as a mismatch on the first cycle it reaches irq_req, irq_vec or rd_data.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int DATA_W      = 8;
   localparam int ADDR_W      = 6;
   localparam int LVL_W       = 2;
   localparam int MAX_EN_REGS = 7;
   localparam int SRC_PER_EN  = 8;
   localparam int SRC_PER_LVL = DATA_W / LVL_W;
   // register map (byte addresses)
   localparam int A_CTRL  = 0;
   localparam int A_EN0   = 1;
   localparam int A_PEND0 = 8;
   localparam int A_LVL0  = 16;
   // control register bit positions
   localparam int C_MIE  = 0;
   localparam int C_MODE = 1;
   localparam int C_SVC  = 2;
   localparam int C_EOI  = 3;
   localparam int C_SLVL = 4;
   localparam int C_NMI  = 7;
   typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int N = 57
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   for (genvar s = 0; s < N; s++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend[s] <= 1'b0;
         else
            pend[s] <= set[s] | (pend[s] & ~clr[s]);
      end
   end

   // a pulse always survives a simultaneous clear
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((pend & $past(set)) == $past(set)));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_pkg::*;
#(
   parameter int NUM_MSK  = 56,
   parameter bit LEVEL_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                svc_set,
   input  lvl_t                svc_set_lvl,
   output logic                mie,
   output logic                lvl_mode,
   output logic [NUM_MSK-1:0]  en,
   output lvl_t [NUM_MSK-1:0]  lvl,
   output logic                svc_active,
   output lvl_t                svc_lvl
);
   logic wr_ctrl;
   assign wr_ctrl = wr_en && (int'(addr) == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mie <= 1'b0;
      end else if (wr_ctrl) begin
         mie <= wr_data[C_MIE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_active <= 1'b0;
         svc_lvl    <= '0;
      end else if (svc_set) begin
         svc_active <= 1'b1;
         svc_lvl    <= svc_set_lvl;
      end else if (wr_ctrl && wr_data[C_EOI]) begin
         svc_active <= 1'b0;
      end
   end

   for (genvar s = 0; s < NUM_MSK; s++) begin : g_en
      localparam int R = s / SRC_PER_EN;
      localparam int B = s % SRC_PER_EN;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en[s] <= 1'b0;
         else if (wr_en && (int'(addr) == A_EN0 + R))
            en[s] <= wr_data[B];
      end
   end

   if (LEVEL_EN) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lvl_mode <= 1'b0;
         else if (wr_ctrl)
            lvl_mode <= wr_data[C_MODE];
      end
      for (genvar s = 0; s < NUM_MSK; s++) begin : g_fld
         localparam int R = s / SRC_PER_LVL;
         localparam int J = s % SRC_PER_LVL;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lvl[s] <= '0;
            else if (wr_en && (int'(addr) == A_LVL0 + R))
               lvl[s] <= wr_data[J*LVL_W +: LVL_W];
         end
      end
   end else begin : g_nolvl
      assign lvl_mode = 1'b0;
      assign lvl      = '0;
   end

   p_svc_rec_r11: assert property (@(posedge clk) disable iff (!rst_n)
      svc_set |=> (svc_active && svc_lvl == $past(svc_set_lvl)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int NUM_MSK = 56,
   parameter int IDX_W   = 6
) (
   input  logic [NUM_MSK:0]    pend,
   input  logic [NUM_MSK-1:0]  en,
   input  lvl_t [NUM_MSK-1:0]  lvl,
   input  logic                mie,
   input  logic                lvl_mode,
   input  logic                svc_active,
   input  lvl_t                svc_lvl,
   output logic                win_valid,
   output logic [IDX_W-1:0]    win_idx
);
   localparam int NSRC  = NUM_MSK + 1;
   localparam int KEY_W = LVL_W + 1;
   localparam logic [KEY_W-1:0] NMI_KEY = KEY_W'(1) << LVL_W;

   logic [NSRC-1:0]             elig;
   logic [NSRC-1:0][KEY_W-1:0]  key;

   always_comb begin
      elig[0] = pend[0];
      key[0]  = NMI_KEY;
      for (int s = 1; s < NSRC; s++) begin
         elig[s] = pend[s] & en[s-1] & mie &
                   (~lvl_mode | ~svc_active | (lvl[s-1] > svc_lvl));
         key[s]  = lvl_mode ? {1'b0, lvl[s-1]} : '0;
      end
   end

   // ascending scan with strict compare: ties keep the smaller number
   always_comb begin
      logic [KEY_W-1:0] best;
      best      = '0;
      win_valid = 1'b0;
      win_idx   = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (elig[s] && (!win_valid || key[s] > best)) begin
            win_valid = 1'b1;
            best      = key[s];
            win_idx   = IDX_W'(s);
         end
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int               NUM_MSK  = 56,
   parameter bit               LEVEL_EN = 1'b1,
   parameter int               VEC_W    = 16,
   parameter logic [VEC_W-1:0] VEC_BASE = 16'h0040
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wdt_pulse,
   input  logic [NUM_MSK-1:0]  src_pulse,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                cpu_ack,
   output logic                irq_req,
   output logic [VEC_W-1:0]    irq_vec
);
   localparam int NSRC     = NUM_MSK + 1;
   localparam int IDX_W    = $clog2(NSRC);
   localparam int EN_REGS  = (NUM_MSK + SRC_PER_EN - 1) / SRC_PER_EN;
   localparam int LVL_REGS = (NUM_MSK + SRC_PER_LVL - 1) / SRC_PER_LVL;

   if (NUM_MSK < 1 || NUM_MSK > MAX_EN_REGS * SRC_PER_EN) begin : g_bad_num
      $error("NUM_MSK out of range");
   end
   if (VEC_W < IDX_W + 2) begin : g_bad_vec
      $error("VEC_W too narrow for the vector table");
   end

   logic [NSRC-1:0]      pend, set_v, clr_v, ack_clr, w1c;
   logic [NUM_MSK-1:0]   en;
   lvl_t [NUM_MSK-1:0]   lvl;
   logic                 mie, lvl_mode, svc_active, svc_set;
   lvl_t                 svc_lvl, svc_lvl_in;
   logic                 win_valid;
   logic [IDX_W-1:0]     win_idx, src_q;
   logic                 req_q;
   logic [VEC_W-1:0]     vec_q;
   logic                 take;

   assign take  = req_q & cpu_ack;
   assign set_v = {src_pulse, wdt_pulse};
   assign w1c[0] = 1'b0;

   for (genvar s = 0; s < NSRC; s++) begin : g_ack
      assign ack_clr[s] = take && (int'(src_q) == s);
   end
   for (genvar s = 1; s < NSRC; s++) begin : g_w1c
      localparam int R = (s - 1) / SRC_PER_EN;
      localparam int B = (s - 1) % SRC_PER_EN;
      assign w1c[s] = wr_en && (int'(addr) == A_PEND0 + R) && wr_data[B];
   end
   assign clr_v = ack_clr | w1c;

   irq_pend_bank #(.N(NSRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .pend(pend)
   );

   always_comb begin
      svc_lvl_in = '0;
      for (int s = 1; s < NSRC; s++)
         if (int'(src_q) == s) svc_lvl_in = lvl[s-1];
   end
   assign svc_set = take && (src_q != '0) && lvl_mode;

   irq_cfg_regs #(.NUM_MSK(NUM_MSK), .LEVEL_EN(LEVEL_EN)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .svc_set(svc_set), .svc_set_lvl(svc_lvl_in),
      .mie(mie), .lvl_mode(lvl_mode), .en(en), .lvl(lvl),
      .svc_active(svc_active), .svc_lvl(svc_lvl)
   );

   irq_arbiter #(.NUM_MSK(NUM_MSK), .IDX_W(IDX_W)) u_arb (
      .pend(pend), .en(en), .lvl(lvl), .mie(mie), .lvl_mode(lvl_mode),
      .svc_active(svc_active), .svc_lvl(svc_lvl),
      .win_valid(win_valid), .win_idx(win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         vec_q <= VEC_BASE;
         src_q <= '0;
      end else if (req_q) begin
         if (cpu_ack) req_q <= 1'b0;
      end else if (win_valid) begin
         req_q <= 1'b1;
         src_q <= win_idx;
         vec_q <= VEC_BASE + (VEC_W'(win_idx) << 1);
      end
   end
   assign irq_req = req_q;
   assign irq_vec = vec_q;

   // register read-back
   logic [EN_REGS*SRC_PER_EN-1:0]  en_pad, pend_pad;
   logic [LVL_REGS*DATA_W-1:0]     lvl_pad;
   always_comb begin
      en_pad   = '0;
      pend_pad = '0;
      lvl_pad  = '0;
      en_pad[NUM_MSK-1:0]         = en;
      pend_pad[NUM_MSK-1:0]       = pend[NSRC-1:1];
      lvl_pad[NUM_MSK*LVL_W-1:0]  = lvl;
   end

   always_comb begin
      rd_data = '0;
      if (int'(addr) == A_CTRL) begin
         rd_data[C_MIE]              = mie;
         rd_data[C_MODE]             = lvl_mode;
         rd_data[C_SVC]              = svc_active;
         rd_data[C_SLVL +: LVL_W]    = svc_lvl;
         rd_data[C_NMI]              = pend[0];
      end
      for (int k = 0; k < EN_REGS; k++) begin
         if (int'(addr) == A_EN0 + k)   rd_data = en_pad[k*SRC_PER_EN +: DATA_W];
         if (int'(addr) == A_PEND0 + k) rd_data = pend_pad[k*SRC_PER_EN +: DATA_W];
      end
      for (int k = 0; k < LVL_REGS; k++)
         if (int'(addr) == A_LVL0 + k)  rd_data = lvl_pad[k*DATA_W +: DATA_W];
   end

   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !cpu_ack) |=> (irq_req && $stable(irq_vec)));
   p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && cpu_ack) |=> !irq_req);
   p_nmi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req && pend[0]) |=> (irq_req && irq_vec == VEC_BASE));
   p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_req) && src_q != '0) |-> $past(mie));
   p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec - VEC_BASE) <= VEC_W'(2 * NUM_MSK));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
   localparam int NM = 56;
   localparam logic [15:0] BASE = 16'h0040;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wdt_pulse = 1'b0, wr_en = 1'b0, cpu_ack = 1'b0;
   logic [NM-1:0] src_pulse = '0;
   logic [5:0] addr = '0;
   logic [7:0] wr_data = '0, rd_data;
   logic irq_req;
   logic [15:0] irq_vec;

   always #5 clk = ~clk;

   irq_prio_ctrl #(.NUM_MSK(NM), .LEVEL_EN(1'b1), .VEC_W(16), .VEC_BASE(BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .wdt_pulse(wdt_pulse), .src_pulse(src_pulse),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .cpu_ack(cpu_ack), .irq_req(irq_req), .irq_vec(irq_vec)
   );

   int n_chk = 0, n_bad = 0;

   // reference model
   logic [NM:0]   m_pend = '0;
   logic [NM-1:0] m_en = '0;
   logic [1:0]    m_lvl [NM];
   logic m_mie = 0, m_mode = 0, m_svc = 0, m_req = 0;
   logic [1:0] m_slvl = 0;
   int m_src = 0;
   logic [15:0] m_vec = BASE;

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int m_win();
      int best, bk, k;
      bit e;
      best = -1; bk = -1;
      for (int s = 0; s <= NM; s++) begin
         if (s == 0) begin
            e = m_pend[0]; k = 4;
         end else begin
            e = m_pend[s] && m_en[s-1] && m_mie &&
                (!m_mode || !m_svc || m_lvl[s-1] > m_slvl);
            k = m_mode ? int'(m_lvl[s-1]) : 0;
         end
         if (e && k > bk) begin bk = k; best = s; end
      end
      return best;
   endfunction

   function automatic logic [7:0] m_read(int a);
      logic [7:0] d;
      d = '0;
      if (a == 0) d = {m_pend[0], 1'b0, m_slvl, 1'b0, m_svc, m_mode, m_mie};
      else if (a >= 1 && a <= 7)
         for (int b = 0; b < 8; b++) d[b] = m_en[(a-1)*8+b];
      else if (a >= 8 && a <= 14)
         for (int b = 0; b < 8; b++) d[b] = m_pend[(a-8)*8+b+1];
      else if (a >= 16 && a <= 29)
         for (int j = 0; j < 4; j++) d[2*j +: 2] = m_lvl[(a-16)*4+j];
      return d;
   endfunction

   // one clock: advance model from pre-edge state and inputs, then compare
   task automatic tick();
      logic [NM:0] clr, n_pend;
      int w;
      int a;
      clr = '0;
      a = int'(addr);
      if (m_req && cpu_ack) clr[m_src] = 1'b1;
      if (wr_en && a >= 8 && a <= 14)
         for (int b = 0; b < 8; b++) if (wr_data[b]) clr[(a-8)*8+b+1] = 1'b1;
      n_pend = {src_pulse, wdt_pulse} | (m_pend & ~clr);
      w = m_win();
      @(posedge clk);
      if (m_req) begin
         if (cpu_ack) begin
            m_req = 0;
            if (m_src != 0 && m_mode) begin m_svc = 1; m_slvl = m_lvl[m_src-1]; end
            else if (wr_en && a == 0 && wr_data[3]) m_svc = 0;
         end else if (wr_en && a == 0 && wr_data[3]) m_svc = 0;
      end else begin
         if (wr_en && a == 0 && wr_data[3]) m_svc = 0;
         if (w >= 0) begin m_req = 1; m_src = w; m_vec = BASE + 16'(2*w); end
      end
      if (wr_en && a == 0) begin m_mie = wr_data[0]; m_mode = wr_data[1]; end
      if (wr_en && a >= 1 && a <= 7)
         for (int b = 0; b < 8; b++) m_en[(a-1)*8+b] = wr_data[b];
      if (wr_en && a >= 16 && a <= 29)
         for (int j = 0; j < 4; j++) m_lvl[(a-16)*4+j] = wr_data[2*j +: 2];
      m_pend = n_pend;
      @(negedge clk);
      wdt_pulse = 0; src_pulse = '0; wr_en = 0; cpu_ack = 0; wr_data = '0;
      chk("R9 req model", {15'd0, irq_req}, {15'd0, m_req});
      chk("R8 vec model", irq_vec, m_vec);
   endtask

   task automatic wr(int a, logic [7:0] d);
      wr_en = 1; addr = 6'(a); wr_data = d;
      tick();
   endtask

   task automatic rd(int a, logic [7:0] exp, string tag);
      addr = 6'(a);
      #1;
      chk(tag, {8'd0, rd_data}, {8'd0, exp});
   endtask

   task automatic ack();
      cpu_ack = 1;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      for (int s = 0; s < NM; s++) m_lvl[s] = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 req", {15'd0, irq_req}, 16'd0);
      chk("R1 vec", irq_vec, BASE);
      rd(0, 8'h00, "R1 ctrl");
      rd(1, 8'h00, "R1 en");
      rd(8, 8'h00, "R1 pend");
      // R2 / R3: pending without enables, then enable
      src_pulse[4] = 1; tick();
      rd(8, 8'h10, "R2 pend bit");
      tick(); tick();
      chk("R3 masked by enables", {15'd0, irq_req}, 16'd0);
      wr(1, 8'h10); tick();
      chk("R3 masked by global", {15'd0, irq_req}, 16'd0);
      wr(0, 8'h01); tick();
      chk("R3 taken", {15'd0, irq_req}, 16'd1);
      chk("R8 vec src5", irq_vec, BASE + 16'd10);
      // R9 hold while a better source arrives
      wr(1, 8'h11);
      src_pulse[0] = 1; tick(); tick();
      chk("R9 held req", {15'd0, irq_req}, 16'd1);
      chk("R9 held vec", irq_vec, BASE + 16'd10);
      ack();
      chk("R9 drop", {15'd0, irq_req}, 16'd0);
      rd(8, 8'h01, "R9 served cleared");
      tick();
      chk("R7 later served", irq_vec, BASE + 16'd2);
      ack();
      // R5 fixed priority
      wr(1, 8'h0F);
      src_pulse[1] = 1; src_pulse[2] = 1; tick(); tick();
      chk("R5 lowest number", irq_vec, BASE + 16'd4);
      ack(); tick();
      chk("R7 loser served", irq_vec, BASE + 16'd6);
      ack();
      // R4 watchdog ignores global enable
      wr(0, 8'h00);
      wdt_pulse = 1; src_pulse[1] = 1; tick(); tick();
      chk("R4 nmi req", {15'd0, irq_req}, 16'd1);
      chk("R4 nmi vec", irq_vec, BASE);
      ack(); tick(); tick();
      chk("R3 masked after nmi", {15'd0, irq_req}, 16'd0);
      rd(8, 8'h02, "R2 still pending");
      wr(8, 8'h02);
      rd(8, 8'h00, "R10 w1c");
      // R6 / R11 level mode
      wr(0, 8'h03);
      wr(16, 8'h68);
      src_pulse[3:0] = 4'hF; tick(); tick();
      chk("R6 level tie", irq_vec, BASE + 16'd4);
      ack();
      rd(0, 8'h27, "R12 ctrl fields");
      tick(); tick();
      chk("R11 held below service", {15'd0, irq_req}, 16'd0);
      wr(17, 8'h03); wr(1, 8'h1F);
      src_pulse[4] = 1; tick(); tick();
      chk("R11 higher preempts", irq_vec, BASE + 16'd10);
      ack();
      wr(0, 8'h0B); tick();
      chk("R11 after end-of-service", irq_vec, BASE + 16'd6);
      ack(); wr(0, 8'h0B); tick();
      chk("R6 next level", irq_vec, BASE + 16'd8);
      ack(); wr(0, 8'h0B); tick();
      chk("R6 lowest level", irq_vec, BASE + 16'd2);
      ack(); wr(0, 8'h0B);
      // R10 set wins over clear
      src_pulse[6] = 1; wr(8, 8'h40);
      rd(8, 8'h40, "R10 set wins");
      wr(8, 8'h40);
      rd(8, 8'h00, "R10 cleared");
      // random phase
      for (int i = 0; i < 6000; i++) begin
         for (int b = 0; b < NM; b++) src_pulse[b] = ($urandom % 64) == 0;
         wdt_pulse = ($urandom % 300) == 0;
         cpu_ack = m_req && (($urandom % 4) == 0);
         if (($urandom % 8) == 0) begin
            int sel;
            wr_en = 1;
            sel = $urandom % 4;
            case (sel)
               0: begin addr = 6'd0;
                        wr_data = (($urandom % 10) == 0) ? 8'h00 : (8'h01 | 8'($urandom & 8'h0A)); end
               1: begin addr = 6'(1 + $urandom % 7);  wr_data = 8'($urandom); end
               2: begin addr = 6'(8 + $urandom % 7);  wr_data = 8'($urandom); end
               default: begin addr = 6'(16 + $urandom % 14); wr_data = 8'($urandom); end
            endcase
         end
         tick();
         begin
            int ra;
            ra = $urandom % 32;
            rd(ra, m_read(ra), "R12 readback");
         end
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule